// File: doc/BRIEF.md
# Burst SRAM Read Stage with Selectable Output Register

This block is the data-out path of a synchronous burst SRAM, together with a small behavioural storage array. Read, write and deselect commands come in already decoded. They are captured on the rising clock edge. The array is written directly from the port inputs under a per-byte mask, and it is read at the registered address. The read data then leaves the block in one of two ways. In flow-through mode it goes straight from the array to the output. In pipeline mode it passes through one more rising-edge register. The mode input is sampled continuously, so the choice can change from one cycle to the next.

The drive-enable output stands for the output drivers. Deselects and writes take effect one stage earlier than the pipelined read data: once a deselect or a write is registered, the drivers turn off at once, even while a read is still in flight. An active-low output-enable can force the drivers off in any cycle without waiting for the clock. It can turn them on only in cycles that carry read data.

A doze request puts the block into a low-activity state two clock edges after it is first sampled high. While dozing, all commands are ignored, the drive-enable stays low and the array keeps its contents. When the request falls, a recovery window of a parameterised number of clocks follows. During this window reads and deselects are accepted. A write is dropped and reported on an error output.

The power sequencing is a four-state machine:
- RUN is normal operation.
- DRAIN is the one cycle after the request is first seen. Commands are still accepted in this state.
- DOZE is the sleeping state.
- WAKE is the recovery window.

The transitions are:
- RUN goes to DRAIN when the request is sampled high.
- DRAIN goes to DOZE when the request is still high, and back to RUN otherwise.
- DOZE goes to WAKE when the request is sampled low.
- WAKE goes to RUN after the recovery count expires.

Top module: `burst_rd_stage`

## Requirements
- R1: In flow-through mode (`pipe_mode` = 0), a read sampled at clock edge k drives the array word at its address on `rdata` with `drive_en` high during the cycle that follows edge k.
- R2: In pipeline mode (`pipe_mode` = 1), the word for a read sampled at edge k appears with `drive_en` high during the cycle after edge k+1. Back-to-back reads deliver one word per cycle. In the cycle right after the first read's edge, `drive_en` is low.
- R3: In pipeline mode, a deselect or a write sampled at edge k+1 forces `drive_en` low during the cycle after edge k+1, even if a read was sampled at edge k.
- R4: `oe_n` high forces `drive_en` low at once, with no clock edge needed. `oe_n` low lets `drive_en` rise only in cycles that carry read data. In flow-through mode, a cycle that follows an edge with no command has `drive_en` low.
- R5: A write sampled at an edge updates byte lane i (bits 8i+7..8i) of the addressed word only where `wr_be[i]` is 1. A read of that address sampled at the next edge returns the updated word.
- R6: When `doze_req` is sampled high at two consecutive edges, the block is asleep from the second edge on, and `drive_en` is low while it is asleep.
- R7: While asleep, reads and writes are ignored: the array keeps its contents and `drive_en` stays low.
- R8: After `doze_req` is sampled low in the asleep state, the next `REC_CYC` edges form the recovery window. Reads in the window are served. A write in the window is dropped and sets `wr_err` high for the cycle after its edge. A write after the window is accepted, with `wr_err` low.
- R9: During and straight after reset, `drive_en` and `wr_err` are low.
- R10: If more than one command is asserted at an edge, deselect takes priority over write, and write takes priority over read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_mode | input | 1 | 1 = pipeline (extra output register), 0 = flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| doze_req | input | 1 | Sleep request, active high |
| cmd_rd | input | 1 | Decoded read command |
| cmd_wr | input | 1 | Decoded write command |
| cmd_desel | input | 1 | Decoded deselect command |
| addr | input | AW | Word address |
| wr_data | input | DW | Write data |
| wr_be | input | DW/8 | Byte-lane write mask, bit i covers bits 8i+7..8i |
| rdata | output | DW | Read data |
| drive_en | output | 1 | Output driver enable |
| wr_err | output | 1 | Write dropped during recovery |

## Verification
The bench changes inputs on the falling edge and samples outputs on the next falling edge. A flow-through result is therefore checked one falling edge after the command's rising edge. A pipeline result is checked one falling edge later. The drive cut-off for deselects and writes is checked at the first falling edge after the deselect or write is registered. The output-enable gate is checked one nanosecond after `oe_n` changes, with no clock edge in between. The doze entry is checked after two request edges, the recovery error one falling edge after the dropped write, and the end of the window after exactly `REC_CYC` wake edges.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_DOZE  = 2'd2,
        ST_WAKE  = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/brs_array.sv
module brs_array #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB   = DW / 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [NB-1:0] be,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    // One storage column per byte lane; the mask picks the columns written.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                cells[wa] <= wd[8*g +: 8];
            end
        end

        assign rd[8*g +: 8] = cells[ra];
    end
endmodule

// File: rtl/brs_power_fsm.sv
module brs_power_fsm
    import burst_rd_pkg::*;
#(
    parameter int REC_CYC = 4,
    localparam int CW     = $clog2(REC_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       doze_req,
    output pwr_state_t st,
    output logic       accept,
    output logic       wr_block,
    output logic       dozing
);
    pwr_state_t     st_n;
    logic [CW-1:0]  cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st    <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt_q;
        unique case (st)
            ST_RUN: begin
                if (doze_req) st_n = ST_DRAIN;
            end
            ST_DRAIN: begin
                st_n = doze_req ? ST_DOZE : ST_RUN;
            end
            ST_DOZE: begin
                if (!doze_req) begin
                    st_n  = ST_WAKE;
                    cnt_n = CW'(REC_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (cnt_q == '0) st_n = ST_RUN;
                else             cnt_n = cnt_q - 1'b1;
            end
            default: st_n = ST_RUN;
        endcase
    end

    always_comb begin
        accept   = (st != ST_DOZE);
        wr_block = (st == ST_WAKE);
        dozing   = (st == ST_DOZE);
    end

    p_enter_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && doze_req) |=> (st == ST_DRAIN));
    p_enter_doze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && doze_req) |=> (st == ST_DOZE));
    p_leave_doze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DOZE && !doze_req) |=> (st == ST_WAKE));
endmodule

// File: rtl/brs_out_stage.sv
module brs_out_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          dozing,
    input  logic          rd_q,
    input  logic          wr_q,
    input  logic          ds_q,
    input  logic [DW-1:0] arr_rd,
    output logic [DW-1:0] rdata,
    output logic          drive_en
);
    logic [DW-1:0] hold_q;
    logic          pv_q;
    logic          live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            pv_q   <= 1'b0;
        end else begin
            pv_q <= rd_q;
            if (rd_q) hold_q <= arr_rd;
        end
    end

    // A deselect or write that has just been registered cuts the drivers
    // one stage ahead of the pipelined data.
    always_comb begin
        if (pipe_mode) begin
            rdata = hold_q;
            live  = pv_q && !ds_q && !wr_q;
        end else begin
            rdata = arr_rd;
            live  = rd_q;
        end
        drive_en = live && !oe_n && !dozing;
    end

    p_scd_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && (ds_q || wr_q)) |-> !drive_en);
    p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);
    p_doze_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dozing |-> !drive_en);
endmodule

// File: rtl/burst_rd_stage.sv
module burst_rd_stage
    import burst_rd_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DW      = 16,
    parameter int REC_CYC = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int NB     = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          doze_req,
    input  logic          cmd_rd,
    input  logic          cmd_wr,
    input  logic          cmd_desel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NB-1:0] wr_be,
    output logic [DW-1:0] rdata,
    output logic          drive_en,
    output logic          wr_err
);
    pwr_state_t    st;
    logic          accept, wr_block, dozing;
    logic          rd_q, wr_q, ds_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] arr_rd;
    logic          take_rd, take_wr, take_ds, core_we;

    brs_power_fsm #(.REC_CYC(REC_CYC)) i_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .doze_req (doze_req),
        .st       (st),
        .accept   (accept),
        .wr_block (wr_block),
        .dozing   (dozing)
    );

    // Priority: deselect over write over read.
    always_comb begin
        take_ds = accept && cmd_desel;
        take_wr = accept && cmd_wr && !cmd_desel;
        take_rd = accept && cmd_rd && !cmd_wr && !cmd_desel;
        core_we = take_wr && !wr_block;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            ds_q   <= 1'b0;
            addr_q <= '0;
            wr_err <= 1'b0;
        end else begin
            rd_q   <= take_rd;
            wr_q   <= core_we;
            ds_q   <= take_ds;
            wr_err <= take_wr && wr_block;
            if (accept) addr_q <= addr;
        end
    end

    brs_array #(.DEPTH(DEPTH), .DW(DW)) i_arr (
        .clk (clk),
        .we  (core_we),
        .wa  (addr),
        .wd  (wr_data),
        .be  (wr_be),
        .ra  (addr_q),
        .rd  (arr_rd)
    );

    brs_out_stage #(.DW(DW)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .dozing    (dozing),
        .rd_q      (rd_q),
        .wr_q      (wr_q),
        .ds_q      (ds_q),
        .arr_rd    (arr_rd),
        .rdata     (rdata),
        .drive_en  (drive_en)
    );

    p_wake_write_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAKE && cmd_wr && !cmd_desel) |=> wr_err);
    p_no_flag_outside_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_WAKE) |=> !wr_err);
    p_doze_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dozing |=> !wr_q && !rd_q);
endmodule

// File: tb/test_burst_rd_stage.sv
`timescale 1ns/1ps
module test_burst_rd_stage;
    localparam int DEPTH = 16;
    localparam int DW    = 16;
    localparam int REC   = 4;
    localparam int AW    = $clog2(DEPTH);
    localparam int NB    = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0, oe_n = 1'b0, doze_req = 1'b0;
    logic          cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_desel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NB-1:0] wr_be = '0;
    logic [DW-1:0] rdata;
    logic          drive_en, wr_err;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    burst_rd_stage #(.DEPTH(DEPTH), .DW(DW), .REC_CYC(REC)) i_burst_rd_stage (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe_n(oe_n),
        .doze_req(doze_req), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_desel(cmd_desel), .addr(addr), .wr_data(wr_data), .wr_be(wr_be),
        .rdata(rdata), .drive_en(drive_en), .wr_err(wr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one command at the falling edge, let it pass a rising edge,
    // return at the following falling edge.
    task automatic cyc(input logic r, input logic w, input logic d,
                       input logic [AW-1:0] a, input logic [DW-1:0] dat,
                       input logic [NB-1:0] be);
        cmd_rd = r; cmd_wr = w; cmd_desel = d;
        addr = a; wr_data = dat; wr_be = be;
        @(posedge clk);
        @(negedge clk);
        cmd_rd = 0; cmd_wr = 0; cmd_desel = 0;
    endtask

    task automatic nop();
        cyc(0, 0, 0, '0, '0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        chk("R9 drive_en in reset", drive_en, 0);
        chk("R9 wr_err in reset", wr_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 drive_en after reset", drive_en, 0);

        // Fill the array, flow-through mode.
        for (int a = 0; a < DEPTH; a++) begin
            exp_mem[a] = DW'((a * 16'h1357) ^ 16'hA5C3);
            cyc(0, 1, 0, AW'(a), exp_mem[a], '1);
        end
        // R1: flow-through reads, result in the cycle after the edge.
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1, 0, 0, AW'(a), '0, '0);
            chk("R1 flow rdata", rdata, exp_mem[a]);
            chk("R1 flow drive", drive_en, 1);
        end
        nop();
        chk("R4 idle cycle undriven", drive_en, 0);

        // R5: byte-masked writes with read on the very next edge.
        cyc(0, 1, 0, 4'd3, 16'hFFFF, 2'b01);
        exp_mem[3] = {exp_mem[3][15:8], 8'hFF};
        cyc(1, 0, 0, 4'd3, '0, '0);
        chk("R5 low lane write", rdata, exp_mem[3]);
        cyc(0, 1, 0, 4'd4, 16'h0000, 2'b10);
        exp_mem[4] = {8'h00, exp_mem[4][7:0]};
        cyc(1, 0, 0, 4'd4, '0, '0);
        chk("R5 high lane write", rdata, exp_mem[4]);
        nop();

        // R10: deselect beats read, write beats read.
        cyc(1, 0, 1, 4'd2, '0, '0);
        chk("R10 deselect over read", drive_en, 0);
        cyc(1, 1, 0, 4'd6, 16'h6666, '1);
        exp_mem[6] = 16'h6666;
        chk("R10 write over read", drive_en, 0);
        cyc(1, 0, 0, 4'd6, '0, '0);
        chk("R10 write landed", rdata, 16'h6666);
        nop();

        // R2: pipeline streaming.
        pipe_mode = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1, 0, 0, AW'(a), '0, '0);
            if (a == 0) begin
                chk("R2 first cycle undriven", drive_en, 0);
            end else begin
                chk("R2 pipe rdata", rdata, exp_mem[a-1]);
                chk("R2 pipe drive", drive_en, 1);
            end
        end
        nop();
        chk("R2 last word", rdata, exp_mem[DEPTH-1]);
        chk("R2 last drive", drive_en, 1);

        // R3: single-cycle deselect and write cut-off.
        cyc(1, 0, 0, 4'd2, '0, '0);
        cyc(0, 0, 1, 4'd0, '0, '0);
        chk("R3 deselect cuts drive", drive_en, 0);
        cyc(1, 0, 0, 4'd7, '0, '0);
        cyc(0, 1, 0, 4'd9, 16'h9A9A, '1);
        exp_mem[9] = 16'h9A9A;
        chk("R3 write cuts drive", drive_en, 0);
        nop();
        cyc(1, 0, 0, 4'd9, '0, '0);
        nop();
        chk("R2 pipe read after write", rdata, exp_mem[9]);
        chk("R2 pipe drive after write", drive_en, 1);

        // R4: asynchronous output enable.
        oe_n = 1'b1; #1;
        chk("R4 oe_n high forces off", drive_en, 0);
        oe_n = 1'b0; #1;
        chk("R4 oe_n low re-enables", drive_en, 1);
        @(negedge clk);
        nop();

        // R6/R7/R8: doze, retention, recovery.
        pipe_mode = 1'b0;
        doze_req = 1'b1;
        nop();
        nop();
        chk("R6 asleep undriven", drive_en, 0);
        cyc(0, 1, 0, 4'd5, 16'h1234, '1);
        cyc(1, 0, 0, 4'd5, '0, '0);
        chk("R7 read ignored asleep", drive_en, 0);
        doze_req = 1'b0;
        nop();
        cyc(0, 1, 0, 4'd5, 16'hBEEF, '1);
        chk("R8 write in recovery flagged", wr_err, 1);
        cyc(1, 0, 0, 4'd5, '0, '0);
        chk("R7 contents kept", rdata, exp_mem[5]);
        chk("R8 read served in recovery", drive_en, 1);
        chk("R8 flag lasts one cycle", wr_err, 0);
        for (int i = 0; i < REC - 2; i++) nop();
        cyc(0, 1, 0, 4'd5, 16'hBEEF, '1);
        chk("R8 write after window no flag", wr_err, 0);
        cyc(1, 0, 0, 4'd5, '0, '0);
        v = 16'hBEEF;
        chk("R8 write after window lands", rdata, v);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule